// File: doc/BRIEF.md
# Streaming NAND Hamming Parity Accumulator

This block sits inline in the data path of a NAND flash controller. As a page is transferred, it builds the running Hamming parity used for single-error correction. Each cycle in which the valid strobe is high, one data byte is accepted and passed straight through to the output. From that byte the block derives six column-parity bits and one overall parity bit. The six column bits are XOR-accumulated into a column parity register.

For every byte with odd overall parity, the current 16-bit byte index is folded into one line parity word. Its bitwise complement is folded into the other word. No separate per-bit line parity network is used. The byte index advances after every accepted byte.

A synchronous clear zeroes all accumulated state before a new page. The controller reads the running values directly from the outputs.

Top module: `nand_parity_acc`

## Requirements
- R1: `out_data` equals `in_data` in the same cycle, with no register in between, whether or not `in_valid` is high.
- R2: Column bit k of an accepted byte is the XOR of those data bits i for which bit (k/2) of the index i equals (k mod 2). So bit0 covers bits {0,2,4,6}, bit1 covers {1,3,5,7}, bit2 covers {0,1,4,5}, bit3 covers {2,3,6,7}, bit4 covers {0..3} and bit5 covers {4..7}. These six bits are XORed into `col_par[5:0]`, and the result is visible after the clock edge that accepts the byte.
- R3: `col_par[7:6]` is always zero.
- R4: For an accepted byte whose eight bits XOR to 1, `line_par0` is XORed with the bitwise complement of `byte_count` and `line_par1` is XORed with `byte_count`. Both use the count value from before the increment. For a byte with even parity, both line words are left unchanged.
- R5: `byte_count` increments by one for every accepted byte, whatever its parity, and wraps from 65535 to 0 with no flag.
- R6: A high `clr` at a clock edge zeroes `col_par`, both line words and `byte_count`. It takes priority over `in_valid`, so the byte offered in that cycle is discarded.
- R7: A high `rst` at a clock edge zeroes the same state as `clr`.
- R8: At an edge where `in_valid` is low and `clr` is low, no accumulated output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the accumulated parity, ahead of a new page |
| in_valid | input | 1 | A data byte is offered in this cycle |
| in_data | input | 8 | Data byte from the flash data path |
| out_data | output | 8 | The same byte, forwarded with zero latency |
| col_par | output | 8 | Column parity (bits 5:0 used; bits 7:6 are zero) |
| line_par0 | output | 16 | Line parity word built from the complemented byte index |
| line_par1 | output | 16 | Line parity word built from the byte index |
| byte_count | output | 16 | Count of bytes accepted since the last clear or reset |

## Verification
The forwarded byte is due in the same cycle as the input. The bench therefore compares it one nanosecond after driving a byte, with no clock edge in between.

Every accumulated value (column parity, both line words and the counter) is due one edge after the accepting edge. The bench drives inputs just after a falling edge and reads the accumulated outputs at the next falling edge, which is half a period after the rising edge that registers them.

The same one-edge rule covers clear and reset. Each of them is held for a single rising edge and then sampled at the following falling edge.

// File: rtl/nand_par_pkg.sv
package nand_par_pkg;

    localparam int BYTE_W   = 8;
    localparam int COL_W    = 6;
    localparam int COLREG_W = 8;
    localparam int CNT_W    = 16;
    localparam int LVL_N    = COL_W / 2;

    // Parity of one byte: six column bits plus the overall parity.
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             odd;
    } byte_par_t;

    // Selects the data bits that feed column bit k: bit i is included
    // when bit (k/2) of i equals (k mod 2).
    function automatic logic [BYTE_W-1:0] col_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int i = 0; i < BYTE_W; i++) begin
            m[i] = (((i >> (k / 2)) & 1) == (k % 2));
        end
        return m;
    endfunction

endpackage

// File: rtl/npa_col_gen.sv
module npa_col_gen
    import nand_par_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    output byte_par_t         par
);
    logic [COL_W-1:0] bits;

    for (genvar g = 0; g < COL_W; g++) begin : g_col
        localparam logic [BYTE_W-1:0] MASK = col_mask(g);
        assign bits[g] = ^(data & MASK);
    end

    assign par.col = bits;
    assign par.odd = ^data;
endmodule

// File: rtl/npa_col_reg.sv
module npa_col_reg
    import nand_par_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                take,
    input  logic [COL_W-1:0]    bits,
    output logic [COLREG_W-1:0] col_q
);
    localparam int PAD_W = COLREG_W - COL_W;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            col_q <= '0;
        end else if (take) begin
            col_q <= {{PAD_W{1'b0}}, col_q[COL_W-1:0] ^ bits};
        end
    end

    // R6: clear empties the column register whatever the strobe did
    p_col_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (col_q == '0));

    // R8: idle edge leaves column parity alone
    p_col_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!take && !clr) |=> $stable(col_q));
endmodule

// File: rtl/npa_line_reg.sv
module npa_line_reg
    import nand_par_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         take,
    input  logic         odd,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] lp0_q,
    output logic [W-1:0] lp1_q
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ONES = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            lp0_q <= '0;
            lp1_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + ONE;
            if (odd) begin
                lp0_q <= lp0_q ^ ~cnt_q;
                lp1_q <= lp1_q ^ cnt_q;
            end
        end
    end

    // R5: one step per accepted byte, modulo 2^W
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (take && !clr) |=> (cnt_q == $past(cnt_q) + ONE));

    // R4: the two words always differ by all-ones or not at all
    p_line_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (take && !clr && odd) |=> ((lp0_q ^ lp1_q) == (ONES ^ $past(lp0_q ^ lp1_q))));

    // R4: even bytes leave both line words unchanged
    p_line_even_r4: assert property (@(posedge clk) disable iff (rst)
        (take && !clr && !odd) |=> ($stable(lp0_q) && $stable(lp1_q)));

    // R6: clear zeroes counter and lines
    p_line_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && lp0_q == '0 && lp1_q == '0));

    // R8: idle edge changes nothing
    p_line_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!take && !clr) |=> ($stable(cnt_q) && $stable(lp0_q) && $stable(lp1_q)));
endmodule

// File: rtl/nand_parity_acc.sv
module nand_parity_acc
    import nand_par_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic [BYTE_W-1:0]   out_data,
    output logic [COLREG_W-1:0] col_par,
    output logic [CNT_W-1:0]    line_par0,
    output logic [CNT_W-1:0]    line_par1,
    output logic [CNT_W-1:0]    byte_count
);
    byte_par_t bp;
    logic      take;

    assign out_data = in_data;
    assign take     = in_valid & ~clr;

    npa_col_gen u_gen (
        .data (in_data),
        .par  (bp)
    );

    npa_col_reg u_col (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .take  (take),
        .bits  (bp.col),
        .col_q (col_par)
    );

    npa_line_reg #(.W(CNT_W)) u_line (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .take  (take),
        .odd   (bp.odd),
        .cnt_q (byte_count),
        .lp0_q (line_par0),
        .lp1_q (line_par1)
    );

    // R3: the unused top bits of the column register stay zero
    p_col_top_zero_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (col_par[COLREG_W-1:COL_W] == '0));

    // R7: reset empties every accumulator
    p_reset_zero_r7: assert property (@(posedge clk)
        rst |=> (col_par == '0 && byte_count == '0 && line_par0 == '0 && line_par1 == '0));
endmodule

// File: tb/nand_parity_acc_test.sv
`timescale 1ns/1ps
module nand_parity_acc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [7:0]  out_data;
    logic [7:0]  col_par;
    logic [15:0] line_par0, line_par1, byte_count;

    int n_chk = 0;
    int n_fail = 0;
    int pt_bad = 0;
    bit done = 0;

    logic [7:0]  m_col;
    logic [15:0] m_l0, m_l1, m_cnt;

    always #2.5 clk = ~clk;

    nand_parity_acc uut (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_data(in_data),
        .out_data(out_data), .col_par(col_par), .line_par0(line_par0),
        .line_par1(line_par1), .byte_count(byte_count)
    );

    // Stimulus table: data byte, expected column bits, expected odd flag
    typedef struct packed { logic [7:0] d; logic [7:0] cb; logic odd; } vec_t;
    localparam vec_t VECS [10] = '{
        '{8'h01, 8'h15, 1'b1}, '{8'h80, 8'h2A, 1'b1}, '{8'h03, 8'h03, 1'b0},
        '{8'hFF, 8'h00, 1'b0}, '{8'h0F, 8'h00, 1'b0}, '{8'h10, 8'h25, 1'b1},
        '{8'h55, 8'h00, 1'b0}, '{8'h05, 8'h0C, 1'b0}, '{8'h07, 8'h1A, 1'b1},
        '{8'h80, 8'h2A, 1'b1}
    };

    // Bitwise reference for the column bits (R2)
    function automatic logic [7:0] ref_col(input logic [7:0] d);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (d[i]) begin
                for (int l = 0; l < 3; l++) r[2*l + ((i >> l) & 1)] ^= 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic ref_odd(input logic [7:0] d);
        int c = 0;
        for (int i = 0; i < 8; i++) c += d[i];
        return (c % 2) == 1;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_col = 0; m_l0 = 0; m_l1 = 0; m_cnt = 0;
    endtask

    // Called just after a falling edge; returns at the next falling edge.
    task automatic feed(input logic [7:0] d);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        if (out_data !== d) pt_bad++;
        m_col ^= ref_col(d);
        if (ref_odd(d)) begin
            m_l0 ^= ~m_cnt;
            m_l1 ^= m_cnt;
        end
        m_cnt++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_model(input string req);
        chk(req, "col_par", {24'h0, col_par}, {24'h0, m_col});
        chk(req, "line_par0", {16'h0, line_par0}, {16'h0, m_l0});
        chk(req, "line_par1", {16'h0, line_par1}, {16'h0, m_l1});
        chk(req, "byte_count", {16'h0, byte_count}, {16'h0, m_cnt});
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  page [128];
        logic [7:0]  ca;
        logic [15:0] a0, a1;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_model("R7");

        // Table walk, accumulating over the table (R2, R4, R5)
        foreach (VECS[k]) begin
            chk("R2", "table ref", {24'h0, ref_col(VECS[k].d)}, {24'h0, VECS[k].cb});
            feed(VECS[k].d);
            check_model("R4");
            chk("R3", "col top bits", {30'h0, col_par[7:6]}, 32'h0);
        end

        // Idle cycles with changing data: no update (R8), pass-through (R1)
        in_data = 8'h01;
        #1;
        chk("R1", "out_data idle", {24'h0, out_data}, 32'h01);
        @(negedge clk);
        in_data = 8'h80;
        @(negedge clk);
        check_model("R8");

        // Clear together with valid: byte dropped (R6)
        clr = 1'b1; in_valid = 1'b1; in_data = 8'h01;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        model_clear();
        check_model("R6");

        // Random pages (R2, R4, R5)
        for (int p = 0; p < 3; p++) begin
            do_clear();
            for (int i = 0; i < 256; i++) feed(8'($urandom_range(0, 255)));
            check_model("R2");
        end

        // All-zero page
        do_clear();
        for (int i = 0; i < 512; i++) feed(8'h00);
        check_model("R4");

        // Single flipped bit: difference locates the bit (R2, R4)
        begin
            int j = 77;
            int b = 5;
            for (int i = 0; i < 128; i++) page[i] = 8'($urandom_range(0, 255));
            do_clear();
            for (int i = 0; i < 128; i++) feed(page[i]);
            ca = col_par; a0 = line_par0; a1 = line_par1;
            do_clear();
            page[j][b] = ~page[j][b];
            for (int i = 0; i < 128; i++) feed(page[i]);
            chk("R2", "flip col diff", {24'h0, ca ^ col_par}, {24'h0, ref_col(8'(1 << b))});
            chk("R4", "flip lp0 diff", {16'h0, a0 ^ line_par0}, {16'h0, ~16'(j)});
            chk("R4", "flip lp1 diff", {16'h0, a1 ^ line_par1}, {16'h0, 16'(j)});
        end

        // Counter wrap (R5)
        do_clear();
        for (int i = 0; i < 65536; i++) feed(8'h00);
        chk("R5", "count wrapped", {16'h0, byte_count}, 32'h0);
        feed(8'h01);
        check_model("R5");
        chk("R4", "lp0 at index 0", {16'h0, line_par0}, 32'h0000FFFF);

        chk("R1", "pass-through mismatches", pt_bad, 0);

        // Reset with a byte offered (R7)
        feed(8'h07);
        rst = 1'b1; in_valid = 1'b1; in_data = 8'h07;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        model_clear();
        check_model("R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule